// File: doc/BRIEF.md
# Bus-Master Completion Interrupt Controller

This block gathers the completion and fault events of a bus-master transfer engine into one active-low interrupt pin toward the add-on side. Three sources are watched: the read transfer count reaching zero, the write transfer count reaching zero, and an error during a bus-master transfer. The transfer counters live elsewhere. Each of them delivers a single-cycle pulse into this block. A separate mailbox interrupt request can be merged onto the same pin.

Every source has a sticky status bit and an enable bit, both held in one control/status register. An event pulse always latches its status bit. Only the enabled sources can pull the pin low. The interrupt is signalled by the falling edge of the pin. Software reads the register to find the cause. It then writes ones to the status bits it has handled, and the pin returns high once no enabled source and no mailbox request remains.

Top module: `bm_irq_ctrl`

## Requirements
- R1: After reset all status bits and all enable bits are 0, `reg_rdata_o` reads 0 and `irq_n_o` is high.
- R2: Status bits sit in register bits [2:0]: bit 0 is read count zero (`rd_zero_i`), bit 1 is write count zero (`wr_zero_i`), bit 2 is transfer error (`xfer_err_i`). A pulse on a source sets its bit, and the bit reads back as 1 from the cycle after the pulse.
- R3: A status bit stays set until software clears it.
- R4: A register write with a 1 in status bit position i clears status bit i only. A 0 in a status bit position leaves that bit unchanged.
- R5: Enable bits sit in register bits [6:4], with bit 4+i enabling source i. Every register write loads all three enable bits from `reg_wdata_i`, and they read back unchanged.
- R6: `irq_n_o` is registered. It goes low in the cycle after any source has both its status and enable bits set, or after `mbox_irq_i` is high.
- R7: A source whose enable bit is 0 still latches its status bit but does not pull `irq_n_o` low.
- R8: If a source pulses in the same cycle as a write that clears it, the status bit ends up set.
- R9: `irq_n_o` stays low until every enabled pending status bit is cleared and `mbox_irq_i` is low. It returns high the cycle after that.
- R10: Register bits 3 and 7 always read 0, even after a write of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_zero_i | input | 1 | Read transfer count reached zero, one-cycle pulse |
| wr_zero_i | input | 1 | Write transfer count reached zero, one-cycle pulse |
| xfer_err_i | input | 1 | Bus-master transfer error, one-cycle pulse |
| mbox_irq_i | input | 1 | Mailbox interrupt request, level, merged onto the pin |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W | Register write data: status clear mask and enable bits |
| reg_rdata_o | output | REG_W | Register read data: status and enable bits |
| irq_n_o | output | 1 | Interrupt to the add-on side, active low |

## Verification
The first tests fire each source with every enable bit off. The status bits must latch while the pin stays high, which separates latching from masking. Next, several sources are left pending and cleared one at a time. That shows whether a clear touches only its own bit, and whether the pin waits for the last enabled source. It also checks that the mailbox input keeps the pin low without touching the status bits. A pulse that coincides with its own clear separates set-wins from clear-wins. A long run of sparse random events, writes and mailbox levels is then compared every cycle with a behavioural model of the register and the pin.

// File: rtl/bm_irq_pkg.sv
package bm_irq_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned STAT_LSB = 0;
  localparam int unsigned EN_LSB   = 4;
  localparam int unsigned REG_W    = 8;

  typedef enum logic [1:0] {
    SRC_RD_DONE  = 2'd0,
    SRC_WR_DONE  = 2'd1,
    SRC_XFER_ERR = 2'd2
  } src_e;
endpackage

// File: rtl/bm_irq_src_cell.sv
module bm_irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_wdata_i,
  output logic st_o,
  output logic en_o,
  output logic req_o
);
  logic st_q, en_q;

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= event_i | (st_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign st_o  = st_q;
  assign en_o  = en_q;
  assign req_o = st_q & en_q;
endmodule

// File: rtl/bm_irq_regif.sv
module bm_irq_regif #(
  parameter int unsigned NUM_SRC  = bm_irq_pkg::NUM_SRC,
  parameter int unsigned STAT_LSB = bm_irq_pkg::STAT_LSB,
  parameter int unsigned EN_LSB   = bm_irq_pkg::EN_LSB,
  parameter int unsigned REG_W    = bm_irq_pkg::REG_W
) (
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_SRC-1:0] st_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               en_we_o,
  output logic [NUM_SRC-1:0] en_wdata_o,
  output logic [REG_W-1:0]   rdata_o
);
  assign en_we_o    = we_i;
  assign en_wdata_o = wdata_i[EN_LSB +: NUM_SRC];
  assign clr_o      = we_i ? wdata_i[STAT_LSB +: NUM_SRC] : '0;

  // unassigned positions read as zero
  always_comb begin
    rdata_o = '0;
    rdata_o[STAT_LSB +: NUM_SRC] = st_i;
    rdata_o[EN_LSB +: NUM_SRC]   = en_i;
  end
endmodule

// File: rtl/bm_irq_pin.sv
module bm_irq_pin #(
  parameter int unsigned NUM_SRC = bm_irq_pkg::NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               mbox_i,
  output logic               irq_n_o
);
  logic irq_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_n_q <= 1'b1;
    else         irq_n_q <= ~((|req_i) | mbox_i);
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/bm_irq_ctrl.sv
module bm_irq_ctrl #(
  parameter int unsigned NUM_SRC  = bm_irq_pkg::NUM_SRC,
  parameter int unsigned STAT_LSB = bm_irq_pkg::STAT_LSB,
  parameter int unsigned EN_LSB   = bm_irq_pkg::EN_LSB,
  parameter int unsigned REG_W    = bm_irq_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_zero_i,
  input  logic             wr_zero_i,
  input  logic             xfer_err_i,
  input  logic             mbox_irq_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_n_o
);
  import bm_irq_pkg::*;

  logic [NUM_SRC-1:0] ev, st, en, req, clr, en_wdata;
  logic               en_we;

  assign ev[SRC_RD_DONE]  = rd_zero_i;
  assign ev[SRC_WR_DONE]  = wr_zero_i;
  assign ev[SRC_XFER_ERR] = xfer_err_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    bm_irq_src_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .event_i   (ev[i]),
      .clr_i     (clr[i]),
      .en_we_i   (en_we),
      .en_wdata_i(en_wdata[i]),
      .st_o      (st[i]),
      .en_o      (en[i]),
      .req_o     (req[i])
    );
  end

  bm_irq_regif #(
    .NUM_SRC(NUM_SRC), .STAT_LSB(STAT_LSB), .EN_LSB(EN_LSB), .REG_W(REG_W)
  ) u_regif (
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .st_i      (st),
    .en_i      (en),
    .clr_o     (clr),
    .en_we_o   (en_we),
    .en_wdata_o(en_wdata),
    .rdata_o   (reg_rdata_o)
  );

  bm_irq_pin #(.NUM_SRC(NUM_SRC)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .mbox_i (mbox_irq_i),
    .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/bm_irq_chk.sv
module bm_irq_chk #(
  parameter int unsigned NUM_SRC  = 3,
  parameter int unsigned STAT_LSB = 0,
  parameter int unsigned EN_LSB   = 4,
  parameter int unsigned REG_W    = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] ev_i,
  input logic               mbox_i,
  input logic               we_i,
  input logic [REG_W-1:0]   wdata_i,
  input logic [REG_W-1:0]   rdata_i,
  input logic               irq_n_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    a_r2_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> rdata_i[STAT_LSB+i]);
    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_i[STAT_LSB+i] && !(we_i && wdata_i[STAT_LSB+i]) |=> rdata_i[STAT_LSB+i]);
    a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && wdata_i[STAT_LSB+i] && !ev_i[i] |=> !rdata_i[STAT_LSB+i]);
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] && we_i && wdata_i[STAT_LSB+i] |=> rdata_i[STAT_LSB+i]);
  end

  a_r5_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rdata_i[EN_LSB +: NUM_SRC] == $past(wdata_i[EN_LSB +: NUM_SRC]));

  a_r6_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> irq_n_i == !($past(|(rdata_i[STAT_LSB +: NUM_SRC] & rdata_i[EN_LSB +: NUM_SRC])) || $past(mbox_i)));
endmodule

bind bm_irq_ctrl bm_irq_chk #(
  .NUM_SRC(NUM_SRC), .STAT_LSB(STAT_LSB), .EN_LSB(EN_LSB), .REG_W(REG_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ev_i   ({xfer_err_i, wr_zero_i, rd_zero_i}),
  .mbox_i (mbox_irq_i),
  .we_i   (reg_we_i),
  .wdata_i(reg_wdata_i),
  .rdata_i(reg_rdata_o),
  .irq_n_i(irq_n_o)
);

// File: tb/bm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module bm_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ev = '0;
  logic       mbox = 1'b0, we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bm_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_zero_i(ev[0]), .wr_zero_i(ev[1]), .xfer_err_i(ev[2]),
    .mbox_irq_i(mbox), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .irq_n_o(irq_n)
  );

  // behavioural reference
  int m_st, m_en, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_irq = 1;
    end else begin
      m_irq = ((m_st & m_en) != 0 || mbox) ? 0 : 1;
      m_st  = int'(ev) | (m_st & ~(we ? int'(wd[2:0]) : 0));
      if (we) m_en = int'(wd[6:4]);
    end
  end

  task automatic check(input string tag);
    logic [7:0] exp_rd;
    exp_rd = {1'b0, 3'(m_en), 1'b0, 3'(m_st)};
    vectors++;
    if (rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s reg_rdata actual=%h expected=%h", tag, rdata, exp_rd);
    end
    vectors++;
    if (irq_n !== 1'(m_irq)) begin
      errors++;
      $display("FAIL %s irq_n actual=%b expected=%0d", tag, irq_n, m_irq);
    end
  endtask

  // drive at a negedge, compare at the next negedge
  task automatic cyc(input logic [2:0] e, input logic mb, input logic w,
                     input logic [7:0] d, input string tag);
    ev = e; mbox = mb; we = w; wd = d;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    cyc(3'b000, 0, 0, 8'h00, "R1");
    // events while disabled: latch, pin stays high
    cyc(3'b001, 0, 0, 8'h00, "R2");
    cyc(3'b010, 0, 0, 8'h00, "R7");
    cyc(3'b100, 0, 0, 8'h00, "R7");
    cyc(3'b000, 0, 0, 8'h00, "R3");
    cyc(3'b000, 0, 0, 8'h00, "R3");
    // enable all; reserved bits written as one
    cyc(3'b000, 0, 1, 8'hF8, "R5");
    cyc(3'b000, 0, 0, 8'h00, "R6");
    cyc(3'b000, 0, 0, 8'h00, "R10");
    // clear one at a time
    cyc(3'b000, 0, 1, 8'h71, "R4");
    cyc(3'b000, 0, 0, 8'h00, "R9");
    cyc(3'b000, 0, 1, 8'h72, "R4");
    cyc(3'b000, 0, 0, 8'h00, "R9");
    cyc(3'b000, 0, 1, 8'h74, "R9");
    cyc(3'b000, 0, 0, 8'h00, "R9");
    // set wins over simultaneous clear
    cyc(3'b010, 0, 1, 8'h72, "R8");
    cyc(3'b000, 0, 0, 8'h00, "R8");
    cyc(3'b000, 0, 1, 8'h72, "R4");
    cyc(3'b000, 0, 0, 8'h00, "R4");
    // mailbox alone
    cyc(3'b000, 1, 0, 8'h00, "R6");
    cyc(3'b000, 1, 0, 8'h00, "R9");
    cyc(3'b000, 0, 0, 8'h00, "R9");
    cyc(3'b000, 0, 0, 8'h00, "R9");
    // masked source with enabled neighbours
    cyc(3'b000, 0, 1, 8'h30, "R5");
    cyc(3'b100, 0, 0, 8'h00, "R7");
    cyc(3'b000, 0, 0, 8'h00, "R7");
    cyc(3'b000, 0, 1, 8'hFF, "R10");
    cyc(3'b000, 0, 0, 8'h00, "R10");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] e;
      e = ($urandom % 5 == 0) ? 3'($urandom) : 3'b000;
      cyc(e, ($urandom % 7 == 0), ($urandom % 4 == 0), 8'($urandom), "R9");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule